// File: doc/BRIEF.md
# Host Request Header Capture Unit

This unit is the receive half of an SPI target that accepts host command requests. It deserialises MOSI bytes (mode 0, most significant bit first) while the chip select is low and stores them in order in a local receive buffer. While the bytes arrive it picks up the version byte, the reserved byte and a 16-bit little-endian length field whose byte offset is programmable. Once the received count equals a programmable target, it raises a valid-length interrupt and judges the 8-byte header. A good header moves the unit to a processing state and yields the expected total request size. A bad header parks it in an error state that discards traffic until the chip select rises.

Firmware programs the target count and the length offset through a small byte-wide write port. It clears the interrupt by writing a one, and it reads the captured request through a random-access read port. A request-done flag tells it when the whole request, as sized by the header, is in the buffer. Every rise of the chip select empties the buffer and returns the unit to its ready state.

Top module: `hcap_top`

## Requirements
- R1: Each byte shifted in on rising `spi_sck` edges while `spi_cs_n` is low (MSB first) is stored at buffer address equal to its arrival index (first byte at 0) and is readable combinationally on `rd_data` for `rd_addr`.
- R2: While `spi_cs_n` is high, `rx_count` is 0 and `rx_state` is 0 (ready); with `spi_cs_n` low the unit leaves ready for 1 (receiving).
- R3: The buffer holds at DEPTH bytes (default 256): further bytes are neither stored nor counted, and earlier contents are kept.
- R4: The length field is taken little-endian from the byte at the programmed offset (low byte) and the next one (high byte); the offset is written at `cfg_addr` 2 (low half) and 3 (high half) and resets to 6. `exp_size` equals 8 plus that field once the target is reached.
- R5: The target count is written at `cfg_addr` 0 (low half) and 1 (high half) and resets to 12; `irq_vlen` sets when `rx_count` reaches the target, and not before.
- R6: `irq_vlen` is cleared only by a write to `cfg_addr` 4 with data bit 0 set; any other write leaves it set.
- R7: At the target, a header with byte 0 equal to 3, byte 5 equal to 0 and an expected size no larger than DEPTH moves `rx_state` to 2 (processing).
- R8: A header failing any R7 condition moves `rx_state` to 3 (bad); bytes received while bad do not change `rx_count`.
- R9: `req_done` is high while the state is processing and `rx_count` is at least `exp_size`, and drops when `spi_cs_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `spi_sck` |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address (0/1 target, 2/3 offset, 4 interrupt clear) |
| cfg_wdata | input | 8 | Configuration write data |
| rd_addr | input | AW | Receive buffer read address |
| rd_data | output | 8 | Receive buffer byte at `rd_addr` |
| irq_vlen | output | 1 | Valid-length interrupt, write-one-to-clear |
| req_done | output | 1 | Full request received |
| rx_state | output | 2 | 0 ready, 1 receiving, 2 processing, 3 bad |
| rx_count | output | CW | Bytes stored in the current frame |
| exp_size | output | 17 | Expected request size from the header |

## Verification
The hardest condition to reach is the saturated buffer while the header is still valid. It needs a request whose length field sizes it at exactly DEPTH bytes, followed by bytes beyond that, so that both the done flag and the hold-when-full behaviour can be seen in one frame. The bench sends a full 256-byte request with a length field of 248, then keeps clocking extra bytes. It checks that the count stays at 256 and that the last buffered byte is unchanged. A length of 249 confirms the size limit on the other side of the boundary.

// File: rtl/hcap_pkg.sv
package hcap_pkg;
   typedef enum logic [1:0] {
      ST_READY = 2'd0,
      ST_RECV  = 2'd1,
      ST_PROC  = 2'd2,
      ST_BAD   = 2'd3
   } hcap_state_e;

   localparam int HDR_BYTES = 8;
   localparam int VER_IDX   = 0;
   localparam int RSVD_IDX  = 5;
   localparam logic [7:0] PROTO_VER = 8'd3;

   localparam logic [2:0] CFG_TGT_LO = 3'd0;
   localparam logic [2:0] CFG_TGT_HI = 3'd1;
   localparam logic [2:0] CFG_OFF_LO = 3'd2;
   localparam logic [2:0] CFG_OFF_HI = 3'd3;
   localparam logic [2:0] CFG_IRQ    = 3'd4;
endpackage

// File: rtl/hcap_spi_front.sv
module hcap_spi_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sck,
   input  logic       spi_cs_n,
   input  logic       spi_mosi,
   output logic       byte_valid,
   output logic [7:0] byte_data,
   output logic       cs_idle
);
   localparam int TOP = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hcap_spi_front: SYNC_STAGES must be at least 2");
   end

   logic [TOP:0] sck_s, cs_s, mo_s;
   logic         sck_q;
   logic [2:0]   bit_cnt;
   logic [6:0]   shreg;
   logic         sck_rise;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sck_s[g] <= 1'b0;
            cs_s[g]  <= 1'b1;
            mo_s[g]  <= 1'b0;
         end else if (g == 0) begin
            sck_s[g] <= spi_sck;
            cs_s[g]  <= spi_cs_n;
            mo_s[g]  <= spi_mosi;
         end else begin
            sck_s[g] <= sck_s[(g == 0) ? 0 : g - 1];
            cs_s[g]  <= cs_s[(g == 0) ? 0 : g - 1];
            mo_s[g]  <= mo_s[(g == 0) ? 0 : g - 1];
         end
      end
   end

   assign cs_idle  = cs_s[TOP];
   assign sck_rise = sck_s[TOP] & ~sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q      <= 1'b0;
         bit_cnt    <= '0;
         shreg      <= '0;
         byte_valid <= 1'b0;
         byte_data  <= '0;
      end else begin
         sck_q      <= sck_s[TOP];
         byte_valid <= 1'b0;
         if (cs_idle) begin
            bit_cnt <= '0;
         end else if (sck_rise) begin
            shreg   <= {shreg[5:0], mo_s[TOP]};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               byte_valid <= 1'b1;
               byte_data  <= {shreg, mo_s[TOP]};
            end
         end
      end
   end
endmodule

// File: rtl/hcap_rx_buf.sv
module hcap_rx_buf #(
   parameter int DEPTH = 256,
   parameter int AW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          wr_en,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic [CW-1:0] count,
   output logic          full
);
   logic [7:0] mem [DEPTH];

   assign full    = (count == CW'(DEPTH));
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (wr_en && !full && !clear) mem[count[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count <= '0;
      else if (clear)            count <= '0;
      else if (wr_en && !full)   count <= count + CW'(1);
   end
endmodule

// File: rtl/hcap_hdr_check.sv
module hcap_hdr_check #(
   parameter int DEPTH = 256
) (
   input  logic [7:0]  ver,
   input  logic [7:0]  rsvd,
   input  logic [15:0] len,
   output logic        good,
   output logic [16:0] size
);
   import hcap_pkg::*;

   assign size = 17'(HDR_BYTES) + {1'b0, len};
   assign good = (ver == PROTO_VER) && (rsvd == 8'd0) &&
                 (size != 17'd0) && (size <= 17'(DEPTH));
endmodule

// File: rtl/hcap_top.sv
module hcap_top #(
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2,
   parameter int TGT_RESET   = 12,
   parameter int OFF_RESET   = 6,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          spi_sck,
   input  logic          spi_cs_n,
   input  logic          spi_mosi,
   input  logic          cfg_wr,
   input  logic [2:0]    cfg_addr,
   input  logic [7:0]    cfg_wdata,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic          irq_vlen,
   output logic          req_done,
   output logic [1:0]    rx_state,
   output logic [CW-1:0] rx_count,
   output logic [16:0]   exp_size
);
   import hcap_pkg::*;

   if (DEPTH < HDR_BYTES + 4 || DEPTH > 65535 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("hcap_top: DEPTH must be a power of two between 16 and 32768");
   end

   logic        byte_valid, cs_idle, full, accept, hit, hit_q, irq_clr, good;
   logic [7:0]  byte_data, ver_q, rsvd_q, len_lo, len_hi;
   logic [15:0] tgt_reg, off_reg;
   logic [16:0] cnt_x, off_x, size;
   hcap_state_e state;

   hcap_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .byte_valid(byte_valid), .byte_data(byte_data),
      .cs_idle(cs_idle));

   assign accept = byte_valid && !cs_idle && (state == ST_RECV || state == ST_PROC);

   hcap_rx_buf #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_buf (
      .clk(clk), .rst_n(rst_n), .clear(cs_idle), .wr_en(accept),
      .wr_data(byte_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .count(rx_count), .full(full));

   hcap_hdr_check #(.DEPTH(DEPTH)) u_hdr (
      .ver(ver_q), .rsvd(rsvd_q), .len({len_hi, len_lo}), .good(good), .size(size));

   assign cnt_x   = 17'(rx_count);
   assign off_x   = {1'b0, off_reg};
   assign hit     = accept && !full && (state == ST_RECV) &&
                    (cnt_x + 17'd1 == {1'b0, tgt_reg});
   assign irq_clr = cfg_wr && (cfg_addr == CFG_IRQ) && cfg_wdata[0];

   // programming registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_reg <= 16'(TGT_RESET);
         off_reg <= 16'(OFF_RESET);
      end else if (cfg_wr) begin
         case (cfg_addr)
            CFG_TGT_LO: tgt_reg[7:0]  <= cfg_wdata;
            CFG_TGT_HI: tgt_reg[15:8] <= cfg_wdata;
            CFG_OFF_LO: off_reg[7:0]  <= cfg_wdata;
            CFG_OFF_HI: off_reg[15:8] <= cfg_wdata;
            default: ;
         endcase
      end
   end

   // header field snooping
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ver_q <= '0; rsvd_q <= '0; len_lo <= '0; len_hi <= '0; hit_q <= 1'b0;
      end else if (cs_idle) begin
         ver_q <= '0; rsvd_q <= '0; len_lo <= '0; len_hi <= '0; hit_q <= 1'b0;
      end else begin
         hit_q <= hit;
         if (accept && !full) begin
            if (cnt_x == 17'(VER_IDX))  ver_q  <= byte_data;
            if (cnt_x == 17'(RSVD_IDX)) rsvd_q <= byte_data;
            if (cnt_x == off_x)         len_lo <= byte_data;
            if (cnt_x == off_x + 17'd1) len_hi <= byte_data;
         end
      end
   end

   // request state, expected size and completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_READY;
         exp_size <= '0;
         req_done <= 1'b0;
      end else if (cs_idle) begin
         state    <= ST_READY;
         exp_size <= '0;
         req_done <= 1'b0;
      end else begin
         req_done <= (state == ST_PROC) && (cnt_x >= exp_size);
         case (state)
            ST_READY: state <= ST_RECV;
            ST_RECV: if (hit_q) begin
               exp_size <= size;
               state    <= good ? ST_PROC : ST_BAD;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        irq_vlen <= 1'b0;
      else if (hit_q)    irq_vlen <= 1'b1;
      else if (irq_clr)  irq_vlen <= 1'b0;
   end

   assign rx_state = state;
endmodule

// File: rtl/hcap_checker.sv
module hcap_checker #(
   parameter int DEPTH = 256,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_idle,
   input logic          byte_valid,
   input logic          irq_clr,
   input logic          irq_vlen,
   input logic          req_done,
   input logic [1:0]    rx_state,
   input logic [CW-1:0] rx_count
);
   a_r2_cs_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cs_idle |=> (rx_count == '0) && (rx_state == 2'd0));

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CW'(DEPTH));

   a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == CW'(DEPTH)) && !cs_idle |=> rx_count == CW'(DEPTH));

   a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      irq_vlen && !irq_clr |=> irq_vlen);

   a_r8_bad_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_state == 2'd3) && !cs_idle && byte_valid |=> $stable(rx_count));

   a_r9_done_in_proc: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> rx_state == 2'd2);
endmodule

bind hcap_top hcap_checker #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .byte_valid(byte_valid),
   .irq_clr(irq_clr), .irq_vlen(irq_vlen), .req_done(req_done),
   .rx_state(rx_state), .rx_count(rx_count));

// File: tb/hcap_top_bench.sv
`timescale 1ns/1ps
module hcap_top_bench;
   localparam int DEPTH = 256;
   localparam int AW = 8;
   localparam int CW = 9;

   logic clk = 1'b0, rst_n = 1'b0;
   logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic cfg_wr = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic irq_vlen, req_done;
   logic [1:0] rx_state;
   logic [CW-1:0] rx_count;
   logic [16:0] exp_size;

   int total = 0, bad = 0;
   logic [7:0] sent [DEPTH + 8];
   int nsent = 0;

   always #2.5 clk = ~clk;

   hcap_top u_hcap_top (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_vlen(irq_vlen), .req_done(req_done), .rx_state(rx_state),
      .rx_count(rx_count), .exp_size(exp_size));

   task automatic chk(input string req, input int got, input int expv);
      total++;
      if (got != expv) begin
         bad++;
         $display("FAIL %s got=%0d expected=%0d", req, got, expv);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic spi_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         spi_mosi = b[i];
         wclk(4); spi_sck = 1'b1;
         wclk(4); spi_sck = 1'b0;
      end
      if (nsent < DEPTH + 8) sent[nsent] = b;
      nsent++;
      wclk(8);
   endtask

   task automatic cs_low();
      nsent = 0; spi_cs_n = 1'b0; wclk(6);
   endtask

   task automatic cs_high();
      spi_cs_n = 1'b1; wclk(8);
   endtask

   // header: version, checksum, cmd lo, cmd hi, cmd version, reserved, len lo, len hi
   task automatic send_hdr(input logic [7:0] ver, input logic [7:0] rsvd,
                           input logic [15:0] cmd, input logic [15:0] len);
      spi_byte(ver); spi_byte(8'hA5); spi_byte(cmd[7:0]); spi_byte(cmd[15:8]);
      spi_byte(8'h01); spi_byte(rsvd); spi_byte(len[7:0]); spi_byte(len[15:8]);
   endtask

   task automatic check_buf(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         rd_addr = AW'(i); #1;
         chk(req, int'(rd_data), int'(sent[i]));
      end
   endtask

   initial begin : watchdog
      #900000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      wclk(3); rst_n = 1'b1; wclk(3);
      // R2 reset / idle state
      chk("R2 reset state", int'(rx_state), 0);
      chk("R2 reset count", int'(rx_count), 0);
      chk("R5 reset irq", int'(irq_vlen), 0);
      chk("R9 reset done", int'(req_done), 0);

      // R1 R4 R5 R7 R9 sweep over data lengths
      for (int len = 0; len <= 24; len++) begin
         int nb;
         nb = (8 + len < 12) ? 12 : 8 + len;
         cs_low();
         chk("R2 receiving", int'(rx_state), 1);
         send_hdr(8'd3, 8'd0, 16'h1234, 16'(len));
         for (int k = 8; k < nb; k++) begin
            spi_byte(8'((k * 7 + len) & 8'hFF));
            if (k == 10) begin
               chk("R5 no irq before target", int'(irq_vlen), 0);
               chk("R7 still receiving", int'(rx_state), 1);
            end
            if (k == 11) begin
               chk("R5 irq at target", int'(irq_vlen), 1);
               chk("R7 processing", int'(rx_state), 2);
               chk("R4 exp size", int'(exp_size), 8 + len);
               chk("R9 done at target", int'(req_done), (8 + len <= 12) ? 1 : 0);
            end
         end
         chk("R1 count", int'(rx_count), nb);
         chk("R9 done at end", int'(req_done), 1);
         check_buf("R1 buffer", nb);
         cs_high();
         chk("R2 idle count", int'(rx_count), 0);
         chk("R9 done cleared", int'(req_done), 0);
         cfg(3'd4, 8'h01);
      end

      // R3 full 256-byte request then overflow
      cs_low();
      send_hdr(8'd3, 8'd0, 16'h0042, 16'd248);
      for (int k = 8; k < 256; k++) spi_byte(8'(k ^ 8'h5A));
      chk("R9 done full size", int'(req_done), 1);
      chk("R7 processing full", int'(rx_state), 2);
      spi_byte(8'hEE); spi_byte(8'hDD); spi_byte(8'hCC);
      chk("R3 count held", int'(rx_count), 256);
      rd_addr = 8'd255; #1;
      chk("R3 last byte kept", int'(rd_data), int'(8'(255 ^ 8'h5A)));
      rd_addr = 8'd0; #1;
      chk("R3 first byte kept", int'(rd_data), 3);
      cs_high();
      cfg(3'd4, 8'h01);

      // R7 R8 size one past the buffer
      cs_low();
      send_hdr(8'd3, 8'd0, 16'h0042, 16'd249);
      for (int k = 0; k < 4; k++) spi_byte(8'h11);
      chk("R8 oversize bad", int'(rx_state), 3);
      chk("R5 irq on bad", int'(irq_vlen), 1);
      spi_byte(8'h22); spi_byte(8'h33);
      chk("R8 bytes ignored", int'(rx_count), 12);
      chk("R9 no done when bad", int'(req_done), 0);
      cs_high();
      chk("R2 bad to ready", int'(rx_state), 0);

      // R6 write-one-to-clear
      cfg(3'd4, 8'h00);
      chk("R6 write zero keeps", int'(irq_vlen), 1);
      cfg(3'd0, 8'h0C);
      chk("R6 other addr keeps", int'(irq_vlen), 1);
      cfg(3'd4, 8'h01);
      chk("R6 write one clears", int'(irq_vlen), 0);

      // R8 wrong version and nonzero reserved
      for (int v = 0; v < 6; v++) begin
         logic [7:0] ver, rs;
         ver = (v < 3) ? 8'(v + 1) : 8'd3;
         rs  = (v < 3) ? 8'd0 : 8'(1 << v);
         if (v == 2) ver = 8'd4;
         cs_low();
         send_hdr(ver, rs, 16'h0001, 16'd4);
         for (int k = 0; k < 4; k++) spi_byte(8'h77);
         chk("R8 bad header", int'(rx_state), 3);
         spi_byte(8'h55);
         chk("R8 ignored after bad", int'(rx_count), 12);
         cs_high();
         cfg(3'd4, 8'h01);
      end

      // R4 R5 programmed offset 2 and target 10
      cfg(3'd2, 8'd2); cfg(3'd3, 8'd0);
      cfg(3'd0, 8'd10); cfg(3'd1, 8'd0);
      cs_low();
      send_hdr(8'd3, 8'd0, 16'd5, 16'h0900);
      spi_byte(8'h01);
      chk("R5 no irq at 9", int'(irq_vlen), 0);
      chk("R5 receiving at 9", int'(rx_state), 1);
      spi_byte(8'h02);
      chk("R5 irq at 10", int'(irq_vlen), 1);
      chk("R4 offset length", int'(exp_size), 13);
      chk("R7 processing offset", int'(rx_state), 2);
      chk("R9 not done yet", int'(req_done), 0);
      for (int k = 0; k < 3; k++) spi_byte(8'h03);
      chk("R9 done offset", int'(req_done), 1);
      cs_high();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule